// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write one byte at a time in an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. The host offers a request on a valid/ready handshake; the controller latches the address, the write data and the direction, then walks the RAM control pins through a fixed series of phases. Each phase lasts a whole number of clock cycles, computed at elaboration by rounding the RAM's nanosecond limits up to clock periods.

The data pins are presented as three separate signals: a driven value, a driver enable and a sampled value. The tristate pad itself sits outside the block. A read returns its byte with a one-cycle valid pulse. A write is framed by write-enable inside a window where both chip enables are active, and output-enable stays high for the whole write.

States, all named in `sram_ctrl_pkg`:
- `ST_IDLE` is the only state that accepts a request. It goes to `ST_WR_SETUP` for a write or to `ST_RD_ACCESS` for a read.
- The write path is `ST_WR_SETUP` → `ST_WR_PULSE` → `ST_WR_RECOV` → `ST_WR_PAD` → `ST_IDLE`. The pad state is skipped when its length works out to zero.
- The read path is `ST_RD_ACCESS` → `ST_RD_TURN` → `ST_IDLE`.
- Every transition out of a non-idle state fires on the last cycle of that phase's count.

Top module: `sram_async_ctrl`

## Requirements
- R1: Whenever the controller is idle, the outputs hold these values: `ram_sel_n`=1, `ram_sel`=0, `ram_rd_n`=1, `ram_wr_n`=1, `ram_dq_oe`=0 and `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. With default parameters `req_ready` then stays low for 17 cycles after a write and for 23 cycles after a read.
- R3: A write works as follows:
  - Both chip enables go active on the first cycle after acceptance, with the latched address on `ram_addr`.
  - `ram_wr_n` goes low from the second cycle.
  - Both enables stay active through the recovery cycle, for 15 cycles in total.
  - The address holds steady during that window.
  - `ram_rd_n` stays high throughout the write.
- R4: `ram_dq_oe` is high only during the write-enable low phase and the recovery phase that follows it (14 cycles by default). It is never high while `ram_rd_n` is low.
- R5: The byte on `req_wdata` at acceptance is the value driven on `ram_dq_out` while `ram_wr_n` is low, so it is stored at the requested address.
- R6: A read works as follows:
  - `ram_rd_n` is low and `ram_wr_n` high for 17 cycles, starting on the first cycle after acceptance.
  - `ram_dq_in` is captured on the edge that ends that count.
  - `rd_valid` is then high for exactly one cycle, on cycle 18, with the captured byte on `rd_data`.
- R7: After a read, both enables are inactive and the driver is off for a turnaround phase of at least 6 cycles. The driver never turns on sooner than 6 cycles after `ram_rd_n` rises.
- R8: `ram_wr_n` is low only while `ram_sel_n`=0 and `ram_sel`=1.
- R9: Phase lengths are computed as ceil(limit / clock period), with a minimum of 1. For a 5000 ps clock this gives:
  - address setup: 1 cycle
  - write pulse: 13 cycles, the larger of the 60 ns pulse (12 cycles) and the 70 ns address-to-end-of-write limit less setup (13 cycles)
  - recovery: 1 cycle
  - write pad: 2 cycles, filling out the 85 ns cycle
  - read access: 17 cycles
  - turnaround: 6 cycles

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read byte |
| ram_addr | output | 19 | RAM address pins |
| ram_sel_n | output | 1 | Active-low chip enable |
| ram_sel | output | 1 | Active-high chip enable |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_wr_n | output | 1 | Active-low write enable |
| ram_dq_out | output | 8 | Value to drive onto the data pins |
| ram_dq_oe | output | 1 | Data pin driver enable |
| ram_dq_in | input | 8 | Value sampled from the data pins |

## Verification
The bench writes and then reads back bytes at both address extremes, with data patterns 0xA5, 0x5A and 0xFF, and it also reads a location that was never written. The address extremes show that all 19 address bits are latched rather than just the low ones; the complementary patterns show that every data bit travels in both directions. The RAM model returns a poison byte until the output-enable low time reaches the full access count, so capturing even one cycle early is detected. A read followed at once by a write exercises the turnaround gap: it measures how many cycles separate the rising of output-enable from the controller's driver turning back on.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_WR_PAD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } sram_state_e;

    // Round a picosecond limit up to whole clock periods, never below one.
    function automatic int ps_to_cyc(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    // R9: a running phase counts down by one each cycle
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !last) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end

    // R6: read strobe lasts a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: returned byte holds until the next capture
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(rd_data));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 5000,
    parameter int T_AS_PS  = 0,
    parameter int T_WP_PS  = 60000,
    parameter int T_AW_PS  = 70000,
    parameter int T_WR_PS  = 5000,
    parameter int T_WC_PS  = 85000,
    parameter int T_AA_PS  = 85000,
    parameter int T_RC_PS  = 85000,
    parameter int T_HZ_PS  = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_rd_n,
    output logic              ram_wr_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int AS_CYC   = ps_to_cyc(T_AS_PS, CLK_PS);
    localparam int WP_CYC   = max_int(ps_to_cyc(T_WP_PS, CLK_PS),
                                      ps_to_cyc(T_AW_PS, CLK_PS) - AS_CYC);
    localparam int WR_CYC   = ps_to_cyc(T_WR_PS, CLK_PS);
    localparam int WPAD_CYC = max_int(0, ps_to_cyc(T_WC_PS, CLK_PS)
                                         - AS_CYC - WP_CYC - WR_CYC);
    localparam int AA_CYC   = ps_to_cyc(T_AA_PS, CLK_PS);
    localparam int TURN_CYC = max_int(ps_to_cyc(T_HZ_PS, CLK_PS),
                                      ps_to_cyc(T_RC_PS, CLK_PS) - AA_CYC);
    localparam int MAX_CYC  = max_int(max_int(AS_CYC, WP_CYC),
                              max_int(max_int(WR_CYC, WPAD_CYC),
                                      max_int(AA_CYC, TURN_CYC)));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    sram_state_e      state, state_nxt;
    logic             phase_last;
    logic             accept;
    logic [CNT_W-1:0] phase_load;
    int               phase_len;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Next-state decode.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (accept) state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:  if (phase_last) state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:  if (phase_last) state_nxt = ST_WR_RECOV;
            ST_WR_RECOV:  if (phase_last) state_nxt = (WPAD_CYC > 0) ? ST_WR_PAD : ST_IDLE;
            ST_WR_PAD:    if (phase_last) state_nxt = ST_IDLE;
            ST_RD_ACCESS: if (phase_last) state_nxt = ST_RD_TURN;
            ST_RD_TURN:   if (phase_last) state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Length of the phase about to be entered.
    always_comb begin
        unique case (state_nxt)
            ST_WR_SETUP:  phase_len = AS_CYC;
            ST_WR_PULSE:  phase_len = WP_CYC;
            ST_WR_RECOV:  phase_len = WR_CYC;
            ST_WR_PAD:    phase_len = max_int(WPAD_CYC, 1);
            ST_RD_ACCESS: phase_len = AA_CYC;
            ST_RD_TURN:   phase_len = TURN_CYC;
            default:      phase_len = 1;
        endcase
        phase_load = CNT_W'(phase_len - 1);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Registered pin outputs, decoded from the state being entered so that
    // they change on the same edge as the state and never glitch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            ram_dq_out <= '0;
            ram_sel_n  <= 1'b1;
            ram_sel    <= 1'b0;
            ram_rd_n   <= 1'b1;
            ram_wr_n   <= 1'b1;
            ram_dq_oe  <= 1'b0;
        end else begin
            if (accept) begin
                ram_addr   <= req_addr;
                ram_dq_out <= req_wdata;
            end
            ram_sel_n <= !(state_nxt inside {ST_WR_SETUP, ST_WR_PULSE,
                                             ST_WR_RECOV, ST_RD_ACCESS});
            ram_sel   <=  (state_nxt inside {ST_WR_SETUP, ST_WR_PULSE,
                                             ST_WR_RECOV, ST_RD_ACCESS});
            ram_rd_n  <= (state_nxt != ST_RD_ACCESS);
            ram_wr_n  <= (state_nxt != ST_WR_PULSE);
            ram_dq_oe <= (state_nxt inside {ST_WR_PULSE, ST_WR_RECOV});
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_nxt != state),
        .load_val (phase_load),
        .last     (phase_last)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  ((state == ST_RD_ACCESS) && phase_last),
        .dq_in    (ram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R1: a ready controller has the RAM deselected and its driver off
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_sel_n && !ram_sel && ram_rd_n && ram_wr_n && !ram_dq_oe));

    // R3: address stays put while the RAM remains selected
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n && !$past(ram_sel_n)) |-> $stable(ram_addr));

    // R3: output enable stays high whenever write enable is low
    a_r3_wr_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> ram_rd_n);

    // R4: controller never drives while the RAM may be driving
    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_dq_oe && !ram_rd_n));

    // R7: the driver stays off on the cycle output enable is released
    a_r7_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_rd_n) |-> !ram_dq_oe);

    // R8: write enable only inside an active chip-enable window
    a_r8_wr_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> (!ram_sel_n && ram_sel));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

    localparam int AA = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] ram_addr;
    logic        ram_sel_n, ram_sel, ram_rd_n, ram_wr_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  dq_model = 8'hEE;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
        .ram_rd_n(ram_rd_n), .ram_wr_n(ram_wr_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(dq_model)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // RAM model: stores while written, returns poison until access time met.
    logic [7:0] mem [logic [18:0]];
    int  rcnt = 0;
    int  rd_hi_run = 100;
    bit  prev_oe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_sel_n && ram_sel && !ram_wr_n && ram_dq_oe)
                mem[ram_addr] = ram_dq_out;
            if (!ram_sel_n && ram_sel && !ram_rd_n && ram_wr_n) rcnt++;
            else rcnt = 0;
            if (rcnt >= AA) dq_model = mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
            else            dq_model = 8'hEE;
            if (ram_dq_oe && !prev_oe)
                chk(rd_hi_run >= 6, "R7", "cycles from read release to drive", rd_hi_run, 6);
            prev_oe   = ram_dq_oe;
            rd_hi_run = ram_rd_n ? rd_hi_run + 1 : 0;
        end
    end

    task automatic t_idle(input string tag);
        @(negedge clk);
        chk(ram_sel_n == 1 && ram_sel == 0, "R1", {tag, " enables idle"}, {ram_sel_n, ram_sel}, 2);
        chk(ram_rd_n == 1 && ram_wr_n == 1, "R1", {tag, " strobes idle"}, {ram_rd_n, ram_wr_n}, 3);
        chk(ram_dq_oe == 0 && req_ready == 1, "R1", {tag, " driver off, ready"}, {ram_dq_oe, req_ready}, 1);
    endtask

    task automatic t_write(input logic [18:0] a, input logic [7:0] d);
        int wr_first = -1, wr_cnt = 0, rd_cnt = 0, oe_cnt = 0, sel_cnt = 0, busy = 0, oe_bad = 0;
        bit addr_ok = 1, data_ok = 1;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k == 1) begin req_valid = 0; req_addr = ~a; req_wdata = ~d; end
            if (!ram_wr_n) begin
                wr_cnt++;
                if (wr_first < 0) wr_first = k;
                if (ram_dq_out != d) data_ok = 0;
            end
            if (!ram_rd_n) rd_cnt++;
            if (ram_dq_oe) begin oe_cnt++; if (ram_wr_n && k != 15) oe_bad++; end
            if (!ram_sel_n && ram_sel) begin sel_cnt++; if (ram_addr != a) addr_ok = 0; end
            if (!req_ready && busy == k - 1) busy++;
        end
        chk(busy == 17, "R2", "write busy cycles", busy, 17);
        chk(wr_first == 2, "R3", "write-enable first low cycle", wr_first, 2);
        chk(sel_cnt == 15, "R3", "write select cycles", sel_cnt, 15);
        chk(addr_ok, "R3", "address held during write", addr_ok, 1);
        chk(rd_cnt == 0, "R3", "output enable low during write", rd_cnt, 0);
        chk(wr_cnt == 13, "R9", "write pulse cycles", wr_cnt, 13);
        chk(oe_cnt == 14 && oe_bad == 0, "R4", "driver cycles", oe_cnt, 14);
        chk(data_ok, "R5", "driven byte", data_ok, 1);
        chk(mem.exists(a) && mem[a] == d, "R5", "stored byte",
            mem.exists(a) ? int'(mem[a]) : -1, int'(d));
    endtask

    task automatic t_read(input logic [18:0] a, input logic [7:0] exp, input bit then_write);
        int rd_first = -1, rd_cnt = 0, wr_cnt = 0, oe_cnt = 0, v_cnt = 0, v_at = -1, busy = 0, turn_bad = 0;
        logic [7:0] got = 8'h00;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k == 1) begin req_valid = 0; req_addr = ~a; end
            if (!ram_rd_n) begin rd_cnt++; if (rd_first < 0) rd_first = k; end
            if (!ram_wr_n) wr_cnt++;
            if (ram_dq_oe) oe_cnt++;
            if (rd_valid) begin v_cnt++; v_at = k; got = rd_data; end
            if (k >= 18 && k <= 23 && (!ram_sel_n || ram_sel || ram_dq_oe)) turn_bad++;
            if (!req_ready && busy == k - 1) busy++;
            if (then_write && req_ready && k == busy + 1) break;
        end
        chk(busy == 23, "R2", "read busy cycles", busy, 23);
        chk(rd_first == 1 && rd_cnt == AA, "R6", "output enable low cycles", rd_cnt, AA);
        chk(wr_cnt == 0 && oe_cnt == 0, "R6", "no write or drive in read", wr_cnt + oe_cnt, 0);
        chk(v_cnt == 1 && v_at == 18, "R6", "valid pulse cycle", v_at, 18);
        chk(got == exp, "R6", "read byte", got, exp);
        chk(turn_bad == 0, "R7", "turnaround quiet cycles", turn_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_idle("reset");
        t_write(19'h00000, 8'hA5);
        t_write(19'h7FFFF, 8'h5A);
        t_read(19'h00000, 8'hA5, 0);
        t_read(19'h7FFFF, 8'h5A, 0);
        t_read(19'h12345, 8'h00, 0);
        t_read(19'h7FFFF, 8'h5A, 1);   // R7: write issued the cycle ready returns
        t_write(19'h3C3C3, 8'hFF);
        t_read(19'h3C3C3, 8'hFF, 0);
        t_idle("end");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule